// File: doc/BRIEF.md
# I2C SCL Bit-Rate Generator

This block produces the SCL waveform timing for an I2C master from the peripheral clock. An 11-bit divider is built from two register fields. Five low bits and two control bits (enable and fast-mode select) come from a clock-control input. Six high bits come from a clock-select input. In standard mode the low and high phases have equal length. In fast mode the low phase takes about two thirds of the period and the high phase about one third.

The generator drives `scl_low_o` to pull the line low during the low phase and releases it during the high phase. It gives the byte engine three one-cycle events: a drive strobe when each low phase starts, a tick when each high phase starts, and a sample strobe at the middle of each counted high phase. While a slave holds SCL low, the high-phase count waits, so clock stretching lengthens the high phase. The divider and mode are captured only when a low phase starts, which means a register change never produces a shortened pulse.

Top module: `scl_rate_gen`

## Requirements
- R1: The divider D is the 11-bit value {clk_sel_i[5:0], clk_ctrl_i[4:0]}, with the select field as the upper bits.
- R2: In standard mode (clk_ctrl_i[6]=0), each low phase lasts D+2 cycles and each unstretched high phase lasts D+2 cycles.
- R3: In fast mode (clk_ctrl_i[6]=1), each low phase lasts D+2 cycles and each unstretched high phase lasts floor((D+1)/2)+1 cycles.
- R4: Enable is clk_ctrl_i[5]. In any cycle that follows a clock edge at which enable was 0, scl_low_o and all strobes are 0.
- R5: drive_stb_o is high for exactly one cycle per period, in the first cycle of the low phase, and never outside the low phase.
- R6: sample_stb_o pulses exactly once per high phase, floor(H/2) counted cycles after the high phase starts, where H is the high length. It is only ever high while scl_in_i is high and SCL is released.
- R7: While the generator is in its high phase and scl_in_i is low, the high count does not advance. Holding SCL low for N cycles lengthens the high phase by N cycles.
- R8: New divider or mode values are captured only when a low phase starts. The period that is running finishes with its old timing.
- R9: high_tick_o is high for exactly one cycle, the first cycle of each high phase.
- R10: During and right after reset, SCL is released and all strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_ctrl_i | input | 7 | Divider bits 4:0, enable bit 5, fast-mode bit 6 |
| clk_sel_i | input | 6 | Upper six divider bits |
| scl_in_i | input | 1 | Sampled SCL line level |
| scl_low_o | output | 1 | 1 pulls SCL low (low phase) |
| drive_stb_o | output | 1 | One-cycle pulse at start of low phase |
| high_tick_o | output | 1 | One-cycle pulse at start of high phase |
| sample_stb_o | output | 1 | One-cycle pulse at middle of counted high phase |

## Verification
After a clock edge that sees enable set, scl_low_o and drive_stb_o rise in the next cycle. high_tick_o rises D+2 cycles later. sample_stb_o is combinational on scl_in_i, so it responds within the same cycle. The bench drives inputs and reads outputs on the falling edge only. It counts whole cycles from the drive strobe to the end of the low phase, and then up to the next drive strobe. This gives exact phase lengths and an exact strobe offset for every divider swept. Holds, configuration changes and enable drops are applied on a falling edge. Their effect is checked from the next falling edge on.

// File: rtl/scl_rate_pkg.sv
package scl_rate_pkg;

  typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_HIGH} scl_phase_e;

  // Cycles SCL is driven low for divider value div.
  function automatic int low_len(input int div);
    return div + 2;
  endfunction

  // Cycles of counted high time; fast mode uses half of (div+1).
  function automatic int high_len(input int div, input logic fast);
    return fast ? ((div + 1) >> 1) + 1 : div + 2;
  endfunction

  // Down-counter value at which the sample strobe fires.
  function automatic int mid_of(input int hlen);
    return (hlen - 1) >> 1;
  endfunction

endpackage

// File: rtl/scl_div_calc.sv
module scl_div_calc #(
  parameter int LO_W = 5,
  parameter int HI_W = 6,
  localparam int DIV_W = LO_W + HI_W,
  localparam int CNT_W = DIV_W + 1
) (
  input  logic [LO_W-1:0]  ctl_div,
  input  logic [HI_W-1:0]  sel_div,
  input  logic             fast,
  output logic [CNT_W-1:0] llen,
  output logic [CNT_W-1:0] hlen
);
  logic [DIV_W-1:0] div;

  assign div  = {sel_div, ctl_div};
  assign llen = CNT_W'(scl_rate_pkg::low_len(int'(div)));
  assign hlen = CNT_W'(scl_rate_pkg::high_len(int'(div), fast));
endmodule

// File: rtl/scl_phase_ctr.sv
module scl_phase_ctr #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt,
  output logic             zero
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (load) cnt <= load_val;
    else if (dec)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen #(
  parameter int LO_W = 5,
  parameter int HI_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [LO_W+1:0] clk_ctrl_i,
  input  logic [HI_W-1:0] clk_sel_i,
  input  logic            scl_in_i,
  output logic            scl_low_o,
  output logic            drive_stb_o,
  output logic            high_tick_o,
  output logic            sample_stb_o
);
  import scl_rate_pkg::*;

  localparam int DIV_W  = LO_W + HI_W;
  localparam int CNT_W  = DIV_W + 1;
  localparam int EN_BIT = LO_W;
  localparam int FM_BIT = LO_W + 1;

  scl_phase_e       ph_q, ph_d;
  logic             en, fast;
  logic [CNT_W-1:0] llen_new, hlen_new, hlen_q, mid;
  logic [CNT_W-1:0] cnt, ctr_val;
  logic             zero, ctr_load, ctr_dec;
  logic             start_low, go_high, in_high, in_low;
  logic             drive_q, htick_q;

  assign en   = clk_ctrl_i[EN_BIT];
  assign fast = clk_ctrl_i[FM_BIT];

  scl_div_calc #(.LO_W(LO_W), .HI_W(HI_W)) u_calc (
    .ctl_div (clk_ctrl_i[LO_W-1:0]),
    .sel_div (clk_sel_i),
    .fast    (fast),
    .llen    (llen_new),
    .hlen    (hlen_new)
  );

  scl_phase_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ctr_load),
    .load_val (ctr_val),
    .dec      (ctr_dec),
    .cnt      (cnt),
    .zero     (zero)
  );

  // Named phase events, also observed by the bound checker.
  assign in_low    = (ph_q == PH_LOW);
  assign in_high   = (ph_q == PH_HIGH);
  assign start_low = en && ((ph_q == PH_IDLE) || (in_high && scl_in_i && zero));
  assign go_high   = en && in_low && zero;
  assign ctr_load  = start_low || go_high;
  assign ctr_val   = start_low ? llen_new - 1'b1 : hlen_q - 1'b1;
  assign ctr_dec   = en && !zero && (in_low || (in_high && scl_in_i));
  assign mid       = CNT_W'(mid_of(int'(hlen_q)));

  always_comb begin
    ph_d = ph_q;
    if (!en)           ph_d = PH_IDLE;
    else if (start_low) ph_d = PH_LOW;
    else if (go_high)   ph_d = PH_HIGH;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= PH_IDLE;
      hlen_q  <= '0;
      drive_q <= 1'b0;
      htick_q <= 1'b0;
    end else begin
      ph_q    <= ph_d;
      drive_q <= start_low;
      htick_q <= go_high;
      if (start_low) hlen_q <= hlen_new;
    end
  end

  assign scl_low_o    = in_low;
  assign drive_stb_o  = drive_q;
  assign high_tick_o  = htick_q;
  assign sample_stb_o = in_high && scl_in_i && (cnt == mid);
endmodule

// File: rtl/scl_rate_chk.sv
module scl_rate_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic scl_in,
  input logic scl_low,
  input logic drive_stb,
  input logic high_tick,
  input logic sample_stb,
  input logic in_high
);
  p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!scl_low && !drive_stb && !sample_stb && !high_tick));

  p_drive_in_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    drive_stb |-> scl_low);

  p_drive_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    drive_stb |-> !$past(scl_low));

  p_sample_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> (scl_in && !scl_low));

  p_stretch_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_high && !scl_in && en) |=> in_high);

  p_tick_after_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    high_tick |-> ($past(scl_low) && !scl_low));

  p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({drive_stb, high_tick}));
endmodule

bind scl_rate_gen scl_rate_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en         (en),
  .scl_in     (scl_in_i),
  .scl_low    (scl_low_o),
  .drive_stb  (drive_stb_o),
  .high_tick  (high_tick_o),
  .sample_stb (sample_stb_o),
  .in_high    (in_high)
);

// File: tb/scl_rate_gen_tb_top.sv
module scl_rate_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] ctl = '0;
  logic [5:0] sel = '0;
  logic       hold = 1'b0;
  logic       scl_low, drv, htick, samp, scl_in;
  int         checks = 0;
  int         errors = 0;

  always #2.5 clk = ~clk;
  assign scl_in = ~(scl_low | hold);

  scl_rate_gen dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .clk_ctrl_i   (ctl),
    .clk_sel_i    (sel),
    .scl_in_i     (scl_in),
    .scl_low_o    (scl_low),
    .drive_stb_o  (drv),
    .high_tick_o  (htick),
    .sample_stb_o (samp)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_hi(input int d, input bit fm);
    return fm ? (d + 1) / 2 + 1 : d + 2;
  endfunction

  task automatic set_cfg(input int d, input bit fm, input bit en);
    ctl = {fm, en, d[4:0]};
    sel = d[10:5];
  endtask

  // Measure one period from a drive strobe to the next one.
  task automatic run_period(input int nhold, input bit chg, input int nd, input bit nfm,
                            output int lo, output int hi, output int sp,
                            output int nsp, output int htp, output int nht);
    lo = 0; hi = 0; sp = -1; nsp = 0; htp = -1; nht = 0;
    do @(negedge clk); while (!drv);
    while (scl_low) begin
      if (chg && lo == 0) set_cfg(nd, nfm, 1'b1);
      lo++;
      @(negedge clk);
    end
    while (!drv) begin
      if (samp)  begin sp = hi; nsp++; end
      if (htick) begin htp = hi; nht++; end
      hold = (hi < nhold);
      hi++;
      @(negedge clk);
    end
    hold = 1'b0;
  endtask

  task automatic sweep_one(input int d, input bit fm);
    int lo, hi, sp, nsp, htp, nht, h;
    set_cfg(d, fm, 1'b0);
    repeat (2) @(negedge clk);
    chk("R4 idle scl", int'(scl_low), 0);
    set_cfg(d, fm, 1'b1);
    run_period(0, 1'b0, 0, 1'b0, lo, hi, sp, nsp, htp, nht);
    h = exp_hi(d, fm);
    chk(fm ? "R3 low len" : "R2 low len", lo, d + 2);
    chk(fm ? "R3 high len" : "R2 high len", hi, h);
    chk("R6 sample offset", sp, h / 2);
    chk("R6 sample count", nsp, 1);
    chk("R9 high tick pos", htp, 0);
    chk("R9 high tick count", nht, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lo, hi, sp, nsp, htp, nht;
    // R10: reset state
    repeat (3) @(negedge clk);
    chk("R10 reset scl", int'(scl_low), 0);
    chk("R10 reset strobes", int'(drv | htick | samp), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 after reset", int'(scl_low | drv), 0);

    // R2/R3 sweeps over small dividers
    for (int fm = 0; fm < 2; fm++) begin
      for (int d = 0; d < 10; d++) sweep_one(d, fm[0]);
      // R1: upper bits from the select field
      sweep_one(32, fm[0]);
      sweep_one(3 * 32 + 5, fm[0]);
      sweep_one(2047, fm[0]);
    end

    // R7: stretch by holding SCL low 4 cycles (D=5 std, H=7)
    set_cfg(5, 1'b0, 1'b0);
    repeat (2) @(negedge clk);
    set_cfg(5, 1'b0, 1'b1);
    run_period(4, 1'b0, 0, 1'b0, lo, hi, sp, nsp, htp, nht);
    chk("R7 stretched high", hi, 7 + 4);
    chk("R7 sample offset", sp, 4 + 3);
    chk("R7 sample count", nsp, 1);

    // R8: change D=4 std to D=12 fast during a low phase
    set_cfg(4, 1'b0, 1'b0);
    repeat (2) @(negedge clk);
    set_cfg(4, 1'b0, 1'b1);
    run_period(0, 1'b1, 12, 1'b1, lo, hi, sp, nsp, htp, nht);
    chk("R8 old low kept", lo, 6);
    chk("R8 old high kept", hi, 6);
    run_period(0, 1'b0, 0, 1'b0, lo, hi, sp, nsp, htp, nht);
    chk("R8 new low", lo, 14);
    chk("R8 new high", hi, 7);

    // R4: drop enable during high phase, then during low phase
    set_cfg(6, 1'b0, 1'b1);
    do @(negedge clk); while (!htick);
    set_cfg(6, 1'b0, 1'b0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R4 off in high", int'(scl_low | drv | htick | samp), 0);
    end
    set_cfg(6, 1'b0, 1'b1);
    do @(negedge clk); while (!drv);
    @(negedge clk);
    chk("R5 still low", int'(scl_low), 1);
    chk("R5 single drive", int'(drv), 0);
    set_cfg(6, 1'b0, 1'b0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R4 off in low", int'(scl_low | drv | htick | samp), 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule